// File: doc/BRIEF.md
# Receive Descriptor Chain Walker

This block handles receive buffering for one serial channel. It follows a linked list of four-word descriptors in host memory. A single word-wide request port reaches that memory and serves both descriptor access and data storage. Once a start command gives it a descriptor address, the walker does the following:

- It reads the descriptor's control word and its data pointer.
- It stores each incoming data word at consecutive word addresses of the data section.
- It counts the stored bytes against the section length.
- When it closes a descriptor, it writes back a status word, raises an interrupt event if the close needs one, and follows the next pointer.

The host can set a hold flag in a descriptor so that the walker cannot advance past it. After closing a held descriptor, the walker stalls. It then re-reads the control word and the next pointer each time traffic arrives. While stalled it drops the data and suppresses the interrupts. When the hold flag reads clear, it recovers. In framed mode it discards traffic up to the next frame boundary or abort, then closes with a receive-abort mark. In transparent mode it closes at once with an error interrupt.

Top module: `rx_desc_walker`

## Requirements
- R1: After reset and before the first start command, the walker issues no memory request and raises no interrupt event.
- R2: A descriptor at word address A is laid out as follows:
  - A+0 is a host control word: bit 31 is the hold flag and bits 15:0 are the section length in bytes.
  - A+1 is the status word, the only word the walker writes. Bit 31 is frame end, bit 30 is complete, bit 29 is receive abort, bit 28 is aborted frame, and bits 15:0 are the byte count.
  - A+2 is the next descriptor address.
  - A+3 is the data pointer.
- R3: Received words go to consecutive word addresses starting at the data pointer. Each word adds its byte count (1 to 4) to the running count.
- R4: In framed mode, an end-of-frame event closes the descriptor. The walker writes the status frame end, complete and count, then raises an interrupt with the frame flag set and the error flag clear. It then reads A+2 and branches to the next descriptor.
- R5: In framed mode, an abort event closes the descriptor with status frame end, complete and aborted frame. The interrupt has both the frame flag and the error flag set.
- R6: When the count reaches or passes the section length after a data write, the descriptor closes with status complete and count. This close raises no interrupt and then branches.
- R7: Only one memory request is outstanding at a time. Its address, direction and write data hold steady until it is acknowledged.
- R8: If the closed descriptor's hold flag was set, the walker writes status but does not branch. Every later data word, end-of-frame or abort event then triggers a read of A+0 followed by a read of A+2. While the hold flag reads 1, the data is dropped and no interrupt is raised.
- R9: In framed mode, once a poll reads the hold flag clear, the walker drops data until an end-of-frame or abort event. If the triggering event was itself an end-of-frame or abort, it does not wait. It then writes status frame end, complete, receive abort (plus aborted frame on abort), raises an interrupt with the frame flag set (error flag set on abort), and branches.
- R10: In transparent mode, once a poll reads the hold flag clear, the walker writes status complete and receive abort, raises an interrupt with the error flag set and the frame flag clear, and branches.
- R11: In transparent mode, end-of-frame is ignored while running. An abort raises an interrupt with the error flag only and does not close the descriptor. The mode is held constant while the walker is active.
- R12: A start command accepted while no request is pending branches at once to the given address. It reads the control word there first and never writes status to the descriptor it leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trans_mode | input | 1 | 1 selects transparent mode, 0 selects framed mode |
| init_valid | input | 1 | Start or restart command |
| init_addr | input | AW | Descriptor address for the command |
| rx_valid | input | 1 | Received data word present |
| rx_data | input | 32 | Received data word |
| rx_nbytes | input | 3 | Valid bytes in the word, 1 to 4 |
| rx_eof | input | 1 | End-of-frame event |
| rx_abort | input | 1 | Abort event |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted and completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack on reads |
| irq_valid | output | 1 | Interrupt event pulse |
| irq_fi | output | 1 | Frame flag of the event |
| irq_err | output | 1 | Error flag of the event |

## Verification
The bound assertions check the following on every cycle:
- A pending memory request stays frozen until it is acknowledged.
- A start command yields a control-word read at the commanded address on the next cycle.
- Every interrupt carries a cause.
- Frame-flag interrupts come only right after a memory write.
- Transparent mode never reports a frame flag.

Other behaviours depend on whole sequences and only the bench's scenarios can show them:
- the status word values
- the byte counts for every width and word count
- branching
- where stored words land
- polls repeating under hold
- traffic dropped while stalled
- the recovery rules in both modes

// File: rtl/rx_desc_walker.sv
module rx_desc_walker #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trans_mode,
  input  logic          init_valid,
  input  logic [AW-1:0] init_addr,
  input  logic          rx_valid,
  input  logic [31:0]   rx_data,
  input  logic [2:0]    rx_nbytes,
  input  logic          rx_eof,
  input  logic          rx_abort,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          irq_valid,
  output logic          irq_fi,
  output logic          irq_err
);
  localparam int PADW = 28 - LW;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTRL, S_RD_DPTR, S_RUN, S_WR_DATA, S_WR_STAT,
    S_RD_NEXT, S_HOLD, S_POLL_CTRL, S_POLL_NEXT, S_DISCARD
  } state_t;

  state_t        st;
  logic [AW-1:0] desc, dptr;
  logic [LW-1:0] cnt, len;
  logic [31:0]   dbuf;
  logic          hold, trig_eof, trig_ab;
  logic          s_fe, s_c, s_ra, s_ab, p_fi, p_err;
  logic [31:0]   status_w;

  assign status_w = {s_fe, s_c, s_ra, s_ab, {PADW{1'b0}}, cnt};
  assign mem_req  = (st != S_IDLE) && (st != S_RUN) && (st != S_HOLD) && (st != S_DISCARD);
  assign mem_we   = (st == S_WR_DATA) || (st == S_WR_STAT);
  assign mem_wdata = (st == S_WR_DATA) ? dbuf : status_w;

  always_comb begin
    case (st)
      S_RD_DPTR:               mem_addr = desc + AW'(3);
      S_RD_NEXT, S_POLL_NEXT:  mem_addr = desc + AW'(2);
      S_WR_STAT:               mem_addr = desc + AW'(1);
      S_WR_DATA:               mem_addr = dptr;
      default:                 mem_addr = desc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      desc <= '0; dptr <= '0; cnt <= '0; len <= '0; dbuf <= '0;
      hold <= 1'b0; trig_eof <= 1'b0; trig_ab <= 1'b0;
      s_fe <= 1'b0; s_c <= 1'b0; s_ra <= 1'b0; s_ab <= 1'b0;
      p_fi <= 1'b0; p_err <= 1'b0;
      irq_valid <= 1'b0; irq_fi <= 1'b0; irq_err <= 1'b0;
    end else begin
      irq_valid <= 1'b0;
      if (init_valid && !mem_req) begin
        desc <= init_addr;
        st   <= S_RD_CTRL;
      end else begin
        case (st)
          S_RD_CTRL: if (mem_ack) begin
            len  <= mem_rdata[LW-1:0];
            hold <= mem_rdata[31];
            st   <= S_RD_DPTR;
          end
          S_RD_DPTR: if (mem_ack) begin
            dptr <= mem_rdata[AW-1:0];
            cnt  <= '0;
            st   <= S_RUN;
          end
          S_RUN: begin
            if (rx_abort) begin
              if (trans_mode) begin
                irq_valid <= 1'b1; irq_fi <= 1'b0; irq_err <= 1'b1;
              end else begin
                s_fe <= 1'b1; s_c <= 1'b1; s_ra <= 1'b0; s_ab <= 1'b1;
                p_fi <= 1'b1; p_err <= 1'b1;
                st <= S_WR_STAT;
              end
            end else if (rx_eof && !trans_mode) begin
              s_fe <= 1'b1; s_c <= 1'b1; s_ra <= 1'b0; s_ab <= 1'b0;
              p_fi <= 1'b1; p_err <= 1'b0;
              st <= S_WR_STAT;
            end else if (rx_valid) begin
              dbuf <= rx_data;
              cnt  <= cnt + LW'(rx_nbytes);
              st   <= S_WR_DATA;
            end
          end
          S_WR_DATA: if (mem_ack) begin
            dptr <= dptr + AW'(1);
            if (cnt >= len) begin
              s_fe <= 1'b0; s_c <= 1'b1; s_ra <= 1'b0; s_ab <= 1'b0;
              p_fi <= 1'b0; p_err <= 1'b0;
              st <= S_WR_STAT;
            end else begin
              st <= S_RUN;
            end
          end
          S_WR_STAT: if (mem_ack) begin
            irq_valid <= p_fi | p_err;
            irq_fi    <= p_fi;
            irq_err   <= p_err;
            st        <= hold ? S_HOLD : S_RD_NEXT;
          end
          S_RD_NEXT: if (mem_ack) begin
            desc <= mem_rdata[AW-1:0];
            st   <= S_RD_CTRL;
          end
          S_HOLD: if (rx_valid || rx_eof || rx_abort) begin
            trig_eof <= rx_eof;
            trig_ab  <= rx_abort;
            st       <= S_POLL_CTRL;
          end
          S_POLL_CTRL: if (mem_ack) begin
            hold <= mem_rdata[31];
            st   <= S_POLL_NEXT;
          end
          S_POLL_NEXT: if (mem_ack) begin
            if (hold) begin
              st <= S_HOLD;
            end else if (trans_mode) begin
              s_fe <= 1'b0; s_c <= 1'b1; s_ra <= 1'b1; s_ab <= 1'b0;
              p_fi <= 1'b0; p_err <= 1'b1;
              st <= S_WR_STAT;
            end else if (trig_eof || trig_ab) begin
              s_fe <= 1'b1; s_c <= 1'b1; s_ra <= 1'b1; s_ab <= trig_ab;
              p_fi <= 1'b1; p_err <= trig_ab;
              st <= S_WR_STAT;
            end else begin
              st <= S_DISCARD;
            end
          end
          S_DISCARD: if (rx_eof || rx_abort) begin
            s_fe <= 1'b1; s_c <= 1'b1; s_ra <= 1'b1; s_ab <= rx_abort;
            p_fi <= 1'b1; p_err <= rx_abort;
            st <= S_WR_STAT;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_desc_walker_chk.sv
module rx_desc_walker_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          trans_mode,
  input logic          init_valid,
  input logic [AW-1:0] init_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          irq_valid,
  input logic          irq_fi,
  input logic          irq_err
);
  a_r7_req_stable: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r12_init_read: assert property (@(posedge clk) disable iff (rst)
    init_valid && !mem_req |=> mem_req && !mem_we && (mem_addr == $past(init_addr)));

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_fi || irq_err));

  a_r4_fi_after_status: assert property (@(posedge clk) disable iff (rst)
    irq_valid && irq_fi |-> $past(mem_req && mem_ack && mem_we));

  a_r11_no_fi_transparent: assert property (@(posedge clk) disable iff (rst)
    irq_valid && trans_mode |-> !irq_fi);
endmodule

bind rx_desc_walker rx_desc_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .trans_mode(trans_mode), .init_valid(init_valid),
  .init_addr(init_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .irq_valid(irq_valid),
  .irq_fi(irq_fi), .irq_err(irq_err)
);

// File: tb/tb_rx_desc_walker.sv
module tb_rx_desc_walker;
  localparam int AW = 16;
  localparam logic [31:0] SENT = 32'h0BAD0BAD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trans_mode = 1'b0;
  logic init_valid = 1'b0;
  logic [AW-1:0] init_addr = '0;
  logic rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic [2:0] rx_nbytes = 3'd1;
  logic rx_eof = 1'b0;
  logic rx_abort = 1'b0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic irq_valid, irq_fi, irq_err;

  logic [31:0] mem [0:127];
  int rd_cnt [0:127];
  int wcnt = 0;
  int lat = 0;
  int irq_n = 0;
  logic last_fi = 1'b0, last_err = 1'b0;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_desc_walker #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .trans_mode(trans_mode), .init_valid(init_valid),
    .init_addr(init_addr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_nbytes(rx_nbytes), .rx_eof(rx_eof), .rx_abort(rx_abort),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_valid(irq_valid),
    .irq_fi(irq_fi), .irq_err(irq_err)
  );

  assign mem_ack   = mem_req && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[6:0]];

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we) mem[mem_addr[6:0]] = mem_wdata;
    if (mem_req && mem_ack && !mem_we) rd_cnt[mem_addr[6:0]] = rd_cnt[mem_addr[6:0]] + 1;
    if (!rst && irq_valid) begin
      irq_n = irq_n + 1;
      last_fi = irq_fi;
      last_err = irq_err;
    end
    if (mem_req && !mem_ack) wcnt = wcnt + 1;
    else wcnt = 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input bit tm, input bit hold0, input int len0);
    @(negedge clk);
    rst = 1'b1;
    trans_mode = tm;
    for (int i = 0; i < 128; i++) begin
      mem[i] = '0;
      rd_cnt[i] = 0;
    end
    for (int d = 0; d < 4; d++) begin
      mem[8*d]   = {(d == 0) ? hold0 : 1'b0, 15'b0, (d == 0) ? 16'(len0) : 16'd64};
      mem[8*d+1] = SENT;
      mem[8*d+2] = 32'((8*d + 8) % 32);
      mem[8*d+3] = 32'(40 + 16*d);
    end
    irq_n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_wait();
    repeat (24) @(negedge clk);
  endtask

  task automatic do_init(input int a);
    init_valid = 1'b1; init_addr = AW'(a);
    @(negedge clk);
    init_valid = 1'b0;
    idle_wait();
  endtask

  task automatic send_word(input logic [31:0] d, input int n);
    rx_valid = 1'b1; rx_data = d; rx_nbytes = 3'(n);
    @(negedge clk);
    rx_valid = 1'b0;
    idle_wait();
  endtask

  task automatic send_eof();
    rx_eof = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0;
    idle_wait();
  endtask

  task automatic send_abort();
    rx_abort = 1'b1;
    @(negedge clk);
    rx_abort = 1'b0;
    idle_wait();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: quiet after reset
    start(1'b0, 1'b0, 64);
    repeat (6) @(negedge clk);
    check("R1 mem_req", {31'b0, mem_req}, 32'd0);
    check("R1 irq", 32'(irq_n), 32'd0);

    // R2 R3 R4: framed sweep over byte widths and word counts
    for (int n = 1; n <= 4; n++) begin
      for (int k = 1; k <= 3; k++) begin
        lat = (n + k) % 3;
        start(1'b0, 1'b0, 64);
        do_init(0);
        for (int j = 0; j < k; j++) send_word(32'hC0DE0000 | 32'(n << 8) | 32'(j), n);
        send_eof();
        check("R4 status", mem[1], 32'hC0000000 | 32'(k*n));
        check("R3 first word", mem[40], 32'hC0DE0000 | 32'(n << 8));
        check("R3 last word", mem[40+k-1], 32'hC0DE0000 | 32'(n << 8) | 32'(k-1));
        check("R4 irq", {30'(irq_n), last_fi, last_err}, {30'd1, 1'b1, 1'b0});
        check("R4 branch", 32'(rd_cnt[8] + rd_cnt[11]), 32'd2);
        check("R2 dptr read", 32'(rd_cnt[3]), 32'd1);
      end
    end

    // R6: section full
    lat = 1;
    start(1'b0, 1'b0, 6);
    do_init(0);
    send_word(32'h11111111, 4);
    send_word(32'h22222222, 4);
    check("R6 status", mem[1], 32'h40000008);
    check("R6 no irq", 32'(irq_n), 32'd0);
    send_word(32'h33333333, 4);
    check("R6 next section", mem[56], 32'h33333333);
    send_eof();
    check("R6 next status", mem[9], 32'hC0000004);

    // R5: framed abort
    lat = 2;
    start(1'b0, 1'b0, 64);
    do_init(0);
    send_word(32'hABCD0001, 3);
    send_abort();
    check("R5 status", mem[1], 32'hD0000003);
    check("R5 irq", {30'(irq_n), last_fi, last_err}, {30'd1, 1'b1, 1'b1});

    // R8 R9: framed hold and recovery
    lat = 1;
    start(1'b0, 1'b1, 64);
    do_init(0);
    send_word(32'h0000AAAA, 2);
    send_word(32'h0000BBBB, 2);
    send_eof();
    check("R8 status", mem[1], 32'hC0000004);
    check("R8 irq", 32'(irq_n), 32'd1);
    send_word(32'h0000CCCC, 2);
    check("R8 poll ctrl", 32'(rd_cnt[0]), 32'd2);
    check("R8 poll next", 32'(rd_cnt[2]), 32'd1);
    check("R8 dropped", mem[42], 32'd0);
    send_eof();
    check("R8 event poll", 32'(rd_cnt[0]), 32'd3);
    check("R8 event no irq", 32'(irq_n), 32'd1);
    check("R8 no branch", 32'(rd_cnt[8]), 32'd0);
    mem[0] = 32'd64;
    send_word(32'h0000DDDD, 2);
    check("R9 poll clear", 32'(rd_cnt[0]), 32'd4);
    send_word(32'h0000EEEE, 2);
    check("R9 discard no poll", 32'(rd_cnt[0]), 32'd4);
    check("R9 discard no write", mem[42], 32'd0);
    send_eof();
    check("R9 status", mem[1], 32'hE0000004);
    check("R9 irq", {30'(irq_n), last_fi, last_err}, {30'd2, 1'b1, 1'b0});
    check("R9 branch", 32'(rd_cnt[8]), 32'd1);

    // R9: recovery triggered by abort itself
    start(1'b0, 1'b1, 64);
    do_init(0);
    send_word(32'h00001234, 1);
    send_eof();
    mem[0] = 32'd64;
    send_abort();
    check("R9 abort status", mem[1], 32'hF0000001);
    check("R9 abort irq", {30'(irq_n), last_fi, last_err}, {30'd2, 1'b1, 1'b1});

    // R10: transparent hold and recovery
    lat = 0;
    start(1'b1, 1'b1, 8);
    do_init(0);
    send_word(32'h55555555, 4);
    send_word(32'h66666666, 4);
    check("R10 full status", mem[1], 32'h40000008);
    check("R10 no irq", 32'(irq_n), 32'd0);
    send_word(32'h77777777, 4);
    check("R10 poll", 32'(rd_cnt[0]), 32'd2);
    send_abort();
    check("R10 abort discarded", {30'(rd_cnt[0]), 2'(irq_n)}, {30'd3, 2'd0});
    mem[0] = 32'd8;
    send_word(32'h88888888, 4);
    check("R10 status", mem[1], 32'h60000008);
    check("R10 irq", {30'(irq_n), last_fi, last_err}, {30'd1, 1'b0, 1'b1});
    check("R10 branch", 32'(rd_cnt[8]), 32'd1);

    // R11: transparent run events
    start(1'b1, 1'b0, 64);
    do_init(0);
    send_word(32'h9999AAAA, 4);
    send_eof();
    check("R11 eof ignored", {mem[1][31:0] ^ SENT, 32'(irq_n)} == 64'd0 ? 32'd0 : 32'd1, 32'd0);
    send_abort();
    check("R11 abort irq", {30'(irq_n), last_fi, last_err}, {30'd1, 1'b0, 1'b1});
    check("R11 no close", mem[1], SENT);
    send_word(32'h9999BBBB, 4);
    check("R11 continues", mem[41], 32'h9999BBBB);

    // R12: restart without write-back
    lat = 1;
    start(1'b0, 1'b0, 64);
    do_init(0);
    send_word(32'h12340000, 4);
    do_init(16);
    check("R12 no writeback", mem[1], SENT);
    check("R12 ctrl read", 32'(rd_cnt[16]), 32'd1);
    send_word(32'h12340001, 4);
    check("R12 new section", mem[72], 32'h12340001);
    send_eof();
    check("R12 status", mem[17], 32'hC0000004);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule